// File: doc/BRIEF.md
# Swing-Mode DAC Buffer Sequencer

This block is the data-buffer front end of a buffered digital-to-analog converter. It stores a short table of 12-bit output codes and a read pointer that picks which code currently drives the converter input. A bus master writes a byte to the control register to step the pointer. In practice the master is a DMA channel linked to a sample-collection channel, so one conversion result causes one output step. The pointer moves according to a selectable work mode. The main case is swing mode, where the pointer sweeps up to a programmable limit and then back down to zero with no wrap, so one full sweep holds every code twice.

All configuration goes through one byte-wide, byte-addressed write port. Entry `i` is at addresses `2*i` (low byte) and `2*i+1` (high nibble). The four configuration registers sit directly after the table. The block drives out the selected code, the pointer, top and bottom flags, and a buffer-active indication.

Top module: `dac_buf_seq`

## Requirements
- R1: After reset the pointer is 0, the limit is DEPTH-1 (9), the work mode is swing, the buffer is inactive (`buf_on_o`=0), and entry i holds 100*(i+1).
- R2: `code_o` always equals the table entry selected by `ptr_o`, including the cycle after that entry or the pointer is rewritten.
- R3: In swing mode (mode field 01) the pointer counts up to the limit, holds there for one step while reversing, counts down to 0, and holds there for one step while reversing again. With limit 9, twenty steps return it to 0 heading up.
- R4: A write to the control register (address 2*DEPTH) whose byte has bit 7 (enable), bit 5 (buffer enable) and bit 4 (trigger) all set moves the pointer by exactly one step, visible the cycle after the write. 0xF0 is such a byte.
- R5: A control write stores bit 7 AND bit 5 as `buf_on_o`. A control write without bit 4 never moves the pointer, and cycles without a write leave the pointer and code unchanged.
- R6: A control write with bit 4 set is ignored for stepping when bit 7 or bit 5 of the same byte is clear.
- R7: In normal mode (mode field 00 or 11, address 2*DEPTH+1 bits 1:0) the pointer steps up and wraps from the limit (or above) to 0.
- R8: In one-time-scan mode (mode field 10) the pointer steps up and stops at the limit; further triggers hold it there.
- R9: The limit register (address 2*DEPTH+2, bits 3:0) clamps values above DEPTH-1 to DEPTH-1. `top_o` is 1 when the pointer equals the limit, and `bot_o` is 1 when the pointer is 0.
- R10: A write to address 2*DEPTH+3 (bits 3:0, clamped to DEPTH-1) loads the pointer directly and sets the swing direction to up. A mode write also sets the direction to up.
- R11: A write to address 2*i replaces bits 7:0 of entry i, and a write to 2*i+1 replaces bits 11:8 with data bits 3:0.
- R12: Apart from a direct load or a normal-mode wrap to 0, the pointer changes by at most one position per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Byte address of the write |
| wr_data_i | input | 8 | Write data byte |
| code_o | output | 12 | Code at the current pointer |
| ptr_o | output | 4 | Current read pointer |
| top_o | output | 1 | Pointer equals the limit |
| bot_o | output | 1 | Pointer equals zero |
| buf_on_o | output | 1 | Converter and buffer both enabled |

## Verification
A lost or flipped direction bit shows up on `ptr_o` at the next trigger only in swing mode. There it appears as a missing dwell at an end, or as an early reversal that breaks the 20-step period. A wrong limit or clamp shows up at once in `top_o`, and on the next trigger as a wrap or stop in the wrong place. A corrupted table entry stays hidden until the pointer reaches it, so the bench walks every position and also rewrites an entry and then points at it.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  typedef enum logic [1:0] {
    MODE_NORM  = 2'b00,
    MODE_SWING = 2'b01,
    MODE_SCAN  = 2'b10,
    MODE_NORMX = 2'b11
  } wmode_e;

  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_BUF_BIT = 5;
  localparam int CTRL_TRG_BIT = 4;
endpackage

// File: rtl/dac_seq_cfg.sv
module dac_seq_cfg
  import dac_seq_pkg::*;
#(
  parameter int DEPTH  = 10,
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output wmode_e            mode_o,
  output logic [PTR_W-1:0]  lim_o,
  output logic              buf_on_o,
  output logic              step_o,
  output logic              ld_o,
  output logic [PTR_W-1:0]  ld_val_o,
  output logic              dir_rst_o,
  output logic              ent_we_o,
  output logic [ADDR_W-2:0] ent_idx_o,
  output logic              ent_hi_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(2*DEPTH);
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(2*DEPTH+1);
  localparam logic [ADDR_W-1:0] LIM_A  = ADDR_W'(2*DEPTH+2);
  localparam logic [ADDR_W-1:0] PTR_A  = ADDR_W'(2*DEPTH+3);
  localparam logic [PTR_W-1:0]  MAX_P  = PTR_W'(DEPTH-1);

  logic ctrl_we, mode_we, lim_we, on_new;
  logic [PTR_W-1:0] raw;

  assign ctrl_we = wr_en_i && (wr_addr_i == CTRL_A);
  assign mode_we = wr_en_i && (wr_addr_i == MODE_A);
  assign lim_we  = wr_en_i && (wr_addr_i == LIM_A);
  assign ld_o    = wr_en_i && (wr_addr_i == PTR_A);
  assign on_new  = wr_data_i[CTRL_EN_BIT] & wr_data_i[CTRL_BUF_BIT];
  assign raw     = wr_data_i[PTR_W-1:0];

  // trigger sees the enable bits carried in the same byte
  assign step_o    = ctrl_we && on_new && wr_data_i[CTRL_TRG_BIT];
  assign ld_val_o  = (raw > MAX_P) ? MAX_P : raw;
  assign dir_rst_o = ld_o || mode_we;

  assign ent_we_o  = wr_en_i && (wr_addr_i < CTRL_A);
  assign ent_idx_o = wr_addr_i[ADDR_W-1:1];
  assign ent_hi_o  = wr_addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= MODE_SWING;
      lim_o    <= MAX_P;
      buf_on_o <= 1'b0;
    end else begin
      if (ctrl_we) buf_on_o <= on_new;
      if (mode_we) mode_o   <= wmode_e'(wr_data_i[1:0]);
      if (lim_we)  lim_o    <= (raw > MAX_P) ? MAX_P : raw;
    end
  end
endmodule

// File: rtl/dac_seq_tbl.sv
module dac_seq_tbl #(
  parameter int DEPTH  = 10,
  parameter int CODE_W = 12,
  parameter int PTR_W  = 4,
  parameter int IDX_W  = 4,
  parameter int BASE   = 100,
  parameter int STEP   = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              hi_i,
  input  logic [7:0]        data_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int HI_W = CODE_W - 8;

  logic [CODE_W-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic sel;
    assign sel = we_i && (idx_i == IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tbl[i] <= CODE_W'(BASE + STEP*i);
      end else if (sel) begin
        if (hi_i) tbl[i][CODE_W-1:8] <= data_i[HI_W-1:0];
        else      tbl[i][7:0]        <= data_i;
      end
    end
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ptr_i == PTR_W'(i)) code_o = tbl[i];
  end
endmodule

// File: rtl/dac_seq_ptr.sv
module dac_seq_ptr
  import dac_seq_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  wmode_e           mode_i,
  input  logic [PTR_W-1:0] lim_i,
  input  logic             ld_i,
  input  logic [PTR_W-1:0] ld_val_i,
  input  logic             dir_rst_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             top_o,
  output logic             bot_o
);
  logic             up_q, up_nxt;
  logic [PTR_W-1:0] nxt;
  logic             at_top;

  assign at_top = (ptr_o >= lim_i);

  always_comb begin
    nxt    = ptr_o;
    up_nxt = up_q;
    unique case (mode_i)
      MODE_SWING: begin
        // each end is held for one step while the direction flips
        if (up_q) begin
          if (at_top) up_nxt = 1'b0;
          else        nxt    = ptr_o + 1'b1;
        end else begin
          if (ptr_o == '0) up_nxt = 1'b1;
          else             nxt    = ptr_o - 1'b1;
        end
      end
      MODE_SCAN: nxt = at_top ? ptr_o : ptr_o + 1'b1;
      default:   nxt = at_top ? '0 : ptr_o + 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      up_q  <= 1'b1;
    end else begin
      if (ld_i)        ptr_o <= ld_val_i;
      else if (step_i) ptr_o <= nxt;
      if (dir_rst_i)   up_q  <= 1'b1;
      else if (step_i) up_q  <= up_nxt;
    end
  end

  assign top_o = (ptr_o == lim_i);
  assign bot_o = (ptr_o == '0);
endmodule

// File: rtl/dac_buf_seq.sv
module dac_buf_seq
  import dac_seq_pkg::*;
#(
  parameter  int DEPTH  = 10,
  parameter  int CODE_W = 12,
  parameter  int BASE   = 100,
  parameter  int STEP   = 100,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int ADDR_W = $clog2(2*DEPTH+4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [CODE_W-1:0] code_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              top_o,
  output logic              bot_o,
  output logic              buf_on_o
);
  localparam int IDX_W = ADDR_W - 1;

  wmode_e            mode_q;
  logic [PTR_W-1:0]  lim_q, ld_val;
  logic              step, ld, dir_rst, ent_we, ent_hi;
  logic [IDX_W-1:0]  ent_idx;

  dac_seq_cfg #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mode_o(mode_q), .lim_o(lim_q), .buf_on_o,
    .step_o(step), .ld_o(ld), .ld_val_o(ld_val), .dir_rst_o(dir_rst),
    .ent_we_o(ent_we), .ent_idx_o(ent_idx), .ent_hi_o(ent_hi)
  );

  dac_seq_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i, .rst_ni, .step_i(step), .mode_i(mode_q), .lim_i(lim_q),
    .ld_i(ld), .ld_val_i(ld_val), .dir_rst_i(dir_rst),
    .ptr_o, .top_o, .bot_o
  );

  dac_seq_tbl #(.DEPTH(DEPTH), .CODE_W(CODE_W), .PTR_W(PTR_W), .IDX_W(IDX_W),
                .BASE(BASE), .STEP(STEP)) u_tbl (
    .clk_i, .rst_ni, .we_i(ent_we), .idx_i(ent_idx), .hi_i(ent_hi),
    .data_i(wr_data_i), .ptr_i(ptr_o), .code_o
  );
endmodule

// File: rtl/dac_buf_seq_chk.sv
module dac_buf_seq_chk #(
  parameter int DEPTH  = 10,
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic [PTR_W-1:0]  ptr_o,
  input logic              top_o,
  input logic [1:0]        mode_i,
  input logic [PTR_W-1:0]  lim_i
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(2*DEPTH);
  localparam logic [ADDR_W-1:0] PTR_A  = ADDR_W'(2*DEPTH+3);

  assert_ptr_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= PTR_W'(DEPTH-1));

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ptr_o));

  assert_gated_trig_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == CTRL_A && !(wr_data_i[7] && wr_data_i[5]))
    |=> $stable(ptr_o));

  assert_scan_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && ptr_o >= lim_i && wr_en_i && wr_addr_i == CTRL_A)
    |=> $stable(ptr_o));

  assert_single_step_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == PTR_A) |=>
      (ptr_o == $past(ptr_o)) || (ptr_o == $past(ptr_o) + 1'b1) ||
      (ptr_o + 1'b1 == $past(ptr_o)) || (ptr_o == '0));

  assert_top_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_o |-> (ptr_o == lim_i));
endmodule

bind dac_buf_seq dac_buf_seq_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
  .ptr_o, .top_o, .mode_i(mode_q), .lim_i(lim_q)
);

// File: tb/dac_buf_seq_tb.sv
`timescale 1ns/1ps
module dac_buf_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [11:0] code_o;
  logic [3:0]  ptr_o;
  logic        top_o, bot_o, buf_on_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int    p;
    int    c;
    bit    t;
    bit    b;
    bit    on;
    string tag;
  } exp_t;
  exp_t q[$];

  // reference state
  int m_tbl[10];
  int m_ptr = 0, m_lim = 9, m_mode = 1;
  bit m_up = 1, m_on = 0;

  always #2 clk_i = ~clk_i;

  dac_buf_seq u_dut (.*);

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void m_step();
    case (m_mode)
      1: begin
        if (m_up) begin
          if (m_ptr >= m_lim) m_up = 0; else m_ptr++;
        end else begin
          if (m_ptr == 0) m_up = 1; else m_ptr--;
        end
      end
      2: if (m_ptr < m_lim) m_ptr++;
      default: m_ptr = (m_ptr >= m_lim) ? 0 : m_ptr + 1;
    endcase
  endfunction

  function automatic void m_write(input int a, input int d);
    if (a < 20) begin
      if (a % 2) m_tbl[a/2] = (m_tbl[a/2] & 'hFF) | ((d & 'hF) << 8);
      else       m_tbl[a/2] = (m_tbl[a/2] & 'hF00) | d;
    end else if (a == 20) begin
      m_on = d[7] & d[5];
      if (d[7] & d[5] & d[4]) m_step();
    end else if (a == 21) begin
      m_mode = d & 3; m_up = 1;
    end else if (a == 22) begin
      m_lim = ((d & 'hF) > 9) ? 9 : (d & 'hF);
    end else if (a == 23) begin
      m_ptr = ((d & 'hF) > 9) ? 9 : (d & 'hF); m_up = 1;
    end
  endfunction

  // driver: one write, then push the expected port state
  task automatic wr(input int a, input int d, input string tag);
    exp_t e;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 5'(a); wr_data_i = 8'(d);
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
    m_write(a, d);
    e.p = m_ptr; e.c = m_tbl[m_ptr]; e.t = (m_ptr == m_lim); e.b = (m_ptr == 0);
    e.on = m_on; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "ptr", int'(ptr_o), e.p);
      check(e.tag, "code", int'(code_o), e.c);
      check(e.tag, "top", int'(top_o), int'(e.t));
      check(e.tag, "bot", int'(bot_o), int'(e.b));
      check(e.tag, "buf_on", int'(buf_on_o), int'(e.on));
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 10; i++) m_tbl[i] = 100 * (i + 1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1", "ptr", int'(ptr_o), 0);
    check("R1", "code", int'(code_o), 100);
    check("R1", "bot", int'(bot_o), 1);
    check("R1", "top", int'(top_o), 0);
    check("R1", "buf_on", int'(buf_on_o), 0);

    wr(20, 'h10, "R6");
    wr(20, 'hD0, "R6");
    wr(20, 'hB0 & 'h70, "R6");
    wr(20, 'hA0, "R5");
    for (int i = 0; i < 20; i++) wr(20, 'hF0, "R3/R4/R12");
    check("R3", "ptr_after_20", m_ptr, 0);
    wr(20, 'hF0, "R3");
    wr(20, 'h20, "R5");
    wr(20, 'hF0, "R4");

    // R11 entry rewrite then point at it (R2)
    wr(8, 'hBC, "R11");
    wr(9, 'h0A, "R11");
    wr(23, 4, "R2/R10");
    wr(10, 'h34, "R2/R11");
    wr(23, 5, "R2");
    wr(11, 'hF7, "R2/R11");

    // R10 clamp and direction reset
    wr(23, 'h0F, "R10");
    wr(20, 'hF0, "R3");
    wr(20, 'hF0, "R3");
    wr(23, 5, "R10");
    wr(20, 'hF0, "R10");

    // R7 normal wrap, both encodings
    wr(22, 3, "R9");
    wr(23, 0, "R10");
    wr(21, 0, "R7");
    for (int i = 0; i < 5; i++) wr(20, 'hF0, "R7/R12");
    wr(21, 3, "R7");
    for (int i = 0; i < 5; i++) wr(20, 'hF0, "R7");

    // R8 one-time scan
    wr(21, 2, "R8");
    wr(23, 0, "R8");
    for (int i = 0; i < 6; i++) wr(20, 'hF0, "R8");

    // R9 limit clamp and flags
    wr(22, 'hFF, "R9");
    wr(23, 9, "R9");
    wr(22, 9, "R9");
    // limit 0 swing stays at 0
    wr(21, 1, "R3");
    wr(22, 0, "R9");
    wr(23, 0, "R9");
    for (int i = 0; i < 3; i++) wr(20, 'hF0, "R3/R9");

    // idle cycles hold (R5)
    repeat (4) @(negedge clk_i);
    check("R5", "ptr_idle", int'(ptr_o), m_ptr);

    wait (q.size() == 0);
    @(negedge clk_i);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule